// File: doc/BRIEF.md
# Audio Controller Interrupt Status Aggregator

This block gathers the interrupt sources of an audio link controller into one 32-bit read-only summary word and drives one level-sensitive interrupt request. Three controller-level sources feed it: a response event, a response buffer overrun and a state change on an input data line. It also takes a 3-bit status vector for each of four input streams and four output streams. Each stream vector is OR-reduced into one summary bit. A controller summary bit, a global summary bit and reserved zero bits complete the word.

The summary bits always follow their sources, whatever the enables say. Only the interrupt request is masked, by per-stream enables, a controller enable and a global enable. The word is registered once per clock. A single-cycle read port returns it on the clock after the read strobe. Clearing happens only at the sources. A wake-up from the deep low-power state leaves the summary bits untouched.

Top module: `aud_irq_aggregator`

## Requirements
- R1: Bit 31 of the status word equals the OR of all other bits of the word.
- R2: Bit 30 equals the OR of the response, response-overrun and line-change inputs.
- R3: Each stream summary bit is the OR of the three bits of that stream's status vector. Stream k's vector occupies bits [3k+2:3k] of its input bus.
- R4: Bits 3:0 report input streams 1 to 4 in that order. Bits 7:4 report output streams 1 to 4 in that order.
- R5: Status bits are set whenever their source is active, whatever the state of the enables.
- R6: Bits 29:8 always read zero. After reset, the status word, the read data and the interrupt request are all zero.
- R7: The interrupt request is high exactly when the global enable is high and either bit 30 is set with the controller enable high, or some stream bit is set with its matching enable bit high.
- R8: The status word is registered. It shows the sources as they stood at the previous rising clock edge.
- R9: A power-state wake indication changes neither the status word nor the interrupt request.
- R10: A read strobe sampled high at a clock edge loads the read data with the status word held just before that edge. Without a strobe the read data holds its value. Reads do not alter the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_evt_i | input | 1 | Response event source |
| rsp_ovf_i | input | 1 | Response buffer overrun source |
| line_chg_i | input | 1 | Input-line state change source |
| in_strm_sts_i | input | 12 | Input stream status vectors, 3 bits per stream |
| out_strm_sts_i | input | 12 | Output stream status vectors, 3 bits per stream |
| strm_en_i | input | 8 | Per-stream interrupt enables, same order as bits 7:0 |
| ctrl_en_i | input | 1 | Controller interrupt enable |
| glb_en_i | input | 1 | Global interrupt enable |
| pwr_wake_i | input | 1 | Wake from deep low-power state indication |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data: status word |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong bit in the registered status appears in the read data two edges after the source changes: one edge loads the status and one serves the read. The same error reaches the interrupt request one edge after the source change, once its enable is open. A stream wired to the wrong position shows up as the wrong bit in 7:0 on the first walking-bit read. A bad global bit shows as bit 31 disagreeing with the rest of the word in the same read. Enables that leak into the status path show up in the very first read taken with the enables closed. Walking single bits, all-enables-closed reads, wake pulses and long mixed patterns are compared against a reference model on every clock.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
    localparam int NUM_IN   = 4;
    localparam int NUM_OUT  = 4;
    localparam int SRC_W    = 3;
    localparam int WORD_W   = 32;
    localparam int NUM_STRM = NUM_IN + NUM_OUT;
    localparam int RSVD_W   = WORD_W - 2 - NUM_STRM;

    typedef struct packed {
        logic rsp;
        logic ovf;
        logic line_chg;
    } ctrl_src_t;

    typedef struct packed {
        logic                gis;
        logic                cis;
        logic [RSVD_W-1:0]   rsvd;
        logic [NUM_STRM-1:0] strm;
    } status_word_t;

    function automatic logic ctrl_any(input ctrl_src_t s);
        return s.rsp | s.ovf | s.line_chg;
    endfunction
endpackage

// File: rtl/aud_stream_or.sv
module aud_stream_or #(
    parameter int N_STRM = 4,
    parameter int VEC_W  = 3,
    localparam int BUS_W = N_STRM * VEC_W
) (
    input  logic [BUS_W-1:0]  vec_i,
    output logic [N_STRM-1:0] hit_o
);
    for (genvar k = 0; k < N_STRM; k++) begin : g_strm
        assign hit_o[k] = |vec_i[k*VEC_W +: VEC_W];
    end
endmodule

// File: rtl/aud_status_pack.sv
module aud_status_pack
    import aud_irq_pkg::*;
(
    input  ctrl_src_t           ctrl_i,
    input  logic [NUM_IN-1:0]   in_hit_i,
    input  logic [NUM_OUT-1:0]  out_hit_i,
    output status_word_t        word_o
);
    always_comb begin
        word_o      = '0;
        word_o.strm = {out_hit_i, in_hit_i};
        word_o.cis  = ctrl_any(ctrl_i);
        word_o.gis  = word_o.cis | (|word_o.strm);
    end
endmodule

// File: rtl/aud_irq_gate.sv
module aud_irq_gate
    import aud_irq_pkg::*;
(
    input  status_word_t        sts_i,
    input  logic [NUM_STRM-1:0] strm_en_i,
    input  logic                ctrl_en_i,
    input  logic                glb_en_i,
    output logic                irq_o
);
    logic ctrl_req;
    logic strm_req;
    always_comb begin
        ctrl_req = sts_i.cis & ctrl_en_i;
        strm_req = |(sts_i.strm & strm_en_i);
        irq_o    = glb_en_i & (ctrl_req | strm_req);
    end
endmodule

// File: rtl/aud_irq_aggregator.sv
module aud_irq_aggregator
    import aud_irq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rsp_evt_i,
    input  logic                       rsp_ovf_i,
    input  logic                       line_chg_i,
    input  logic [NUM_IN*SRC_W-1:0]    in_strm_sts_i,
    input  logic [NUM_OUT*SRC_W-1:0]   out_strm_sts_i,
    input  logic [NUM_STRM-1:0]        strm_en_i,
    input  logic                       ctrl_en_i,
    input  logic                       glb_en_i,
    input  logic                       pwr_wake_i,
    input  logic                       rd_en_i,
    output logic [WORD_W-1:0]          rd_data_o,
    output logic                       irq_o
);
    ctrl_src_t           ctrl_src;
    logic [NUM_IN-1:0]   in_hit;
    logic [NUM_OUT-1:0]  out_hit;
    status_word_t        sts_next;
    status_word_t        sts_q;
    logic                unused_wake;

    // Wake has deliberately no path into the summary state.
    assign unused_wake = pwr_wake_i;

    assign ctrl_src = '{rsp: rsp_evt_i, ovf: rsp_ovf_i, line_chg: line_chg_i};

    aud_stream_or #(.N_STRM(NUM_IN), .VEC_W(SRC_W)) u_in_or (
        .vec_i (in_strm_sts_i),
        .hit_o (in_hit)
    );

    aud_stream_or #(.N_STRM(NUM_OUT), .VEC_W(SRC_W)) u_out_or (
        .vec_i (out_strm_sts_i),
        .hit_o (out_hit)
    );

    aud_status_pack u_pack (
        .ctrl_i    (ctrl_src),
        .in_hit_i  (in_hit),
        .out_hit_i (out_hit),
        .word_o    (sts_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q     <= '0;
            rd_data_o <= '0;
        end else begin
            sts_q <= sts_next;
            if (rd_en_i) rd_data_o <= sts_q;
        end
    end

    aud_irq_gate u_gate (
        .sts_i     (sts_q),
        .strm_en_i (strm_en_i),
        .ctrl_en_i (ctrl_en_i),
        .glb_en_i  (glb_en_i),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/aud_irq_checker.sv
module aud_irq_checker
    import aud_irq_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     rsp_evt_i,
    input logic                     rsp_ovf_i,
    input logic                     line_chg_i,
    input logic [NUM_IN*SRC_W-1:0]  in_strm_sts_i,
    input logic [NUM_OUT*SRC_W-1:0] out_strm_sts_i,
    input logic                     glb_en_i,
    input logic                     pwr_wake_i,
    input logic                     rd_en_i,
    input logic [WORD_W-1:0]        rd_data_o,
    input logic                     irq_o,
    input logic [WORD_W-1:0]        sts_q
);
    assert_gis_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[31] == (|rd_data_o[30:0]));

    assert_cis_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sts_q[30] == $past(rsp_evt_i | rsp_ovf_i | line_chg_i));

    assert_strm_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sts_q[0] == $past(|in_strm_sts_i[2:0]));

    assert_order_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sts_q[4] == $past(|out_strm_sts_i[2:0]));

    assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[29:8] == '0);

    assert_glb_off_R7: assert property (@(posedge clk) disable iff (rst)
        !glb_en_i |-> !irq_o);

    assert_irq_src_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> sts_q[31]);

    assert_wake_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_wake_i |=> sts_q[31] == $past(rsp_evt_i | rsp_ovf_i | line_chg_i
                                           | (|in_strm_sts_i) | (|out_strm_sts_i)));

    assert_read_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_data_o == $past(sts_q));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

bind aud_irq_aggregator aud_irq_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .rsp_evt_i      (rsp_evt_i),
    .rsp_ovf_i      (rsp_ovf_i),
    .line_chg_i     (line_chg_i),
    .in_strm_sts_i  (in_strm_sts_i),
    .out_strm_sts_i (out_strm_sts_i),
    .glb_en_i       (glb_en_i),
    .pwr_wake_i     (pwr_wake_i),
    .rd_en_i        (rd_en_i),
    .rd_data_o      (rd_data_o),
    .irq_o          (irq_o),
    .sts_q          (sts_q)
);

// File: tb/aud_irq_aggregator_test.sv
module aud_irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rsp_evt_i = 0, rsp_ovf_i = 0, line_chg_i = 0;
    logic [11:0] in_strm_sts_i = '0, out_strm_sts_i = '0;
    logic [7:0]  strm_en_i = '0;
    logic        ctrl_en_i = 0, glb_en_i = 0, pwr_wake_i = 0, rd_en_i = 0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic model_on = 1'b0;

    // reference state
    logic [31:0] m_sts = '0;
    logic [31:0] m_rd  = '0;

    always #2.5 clk = ~clk;

    aud_irq_aggregator uut (.*);

    function automatic logic [31:0] ref_word();
        logic [31:0] w = '0;
        for (int s = 0; s < 4; s++) begin
            w[s]     = (in_strm_sts_i[3*s +: 3]  != 3'b000);
            w[4 + s] = (out_strm_sts_i[3*s +: 3] != 3'b000);
        end
        w[30] = rsp_evt_i || rsp_ovf_i || line_chg_i;
        w[31] = (w[30] || w[7:0] != 8'h00);
        return w;
    endfunction

    function automatic logic ref_irq();
        logic any = 1'b0;
        if (ctrl_en_i && m_sts[30]) any = 1'b1;
        for (int s = 0; s < 8; s++) if (strm_en_i[s] && m_sts[s]) any = 1'b1;
        return glb_en_i && any;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sts = '0;
            m_rd  = '0;
        end else begin
            if (rd_en_i) m_rd = m_sts;
            m_sts = ref_word();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (model_on && !rst) begin
            check("R10 read data vs model", rd_data_o, m_rd);
            check("R1 bit31",               {31'd0, rd_data_o[31]}, {31'd0, |rd_data_o[30:0]});
            check("R6 reserved zero",       {10'd0, rd_data_o[29:8]}, 32'd0);
            check("R7 irq vs model",        {31'd0, irq_o}, {31'd0, ref_irq()});
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // load sources, let status register take them, then read
    task automatic read_word(input string tag, input logic [31:0] exp);
        step();
        rd_en_i = 1;
        step();
        rd_en_i = 0;
        check(tag, rd_data_o, exp);
    endtask

    task automatic clear_src();
        rsp_evt_i = 0; rsp_ovf_i = 0; line_chg_i = 0;
        in_strm_sts_i = '0; out_strm_sts_i = '0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        check("R6 reset read data", rd_data_o, 32'h0);
        check("R6 reset irq", {31'd0, irq_o}, 32'h0);
        rst = 0;
        model_on = 1;
        step();

        // R3 R4: walk every bit of every stream vector, enables closed (R5)
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 3; b++) begin
                clear_src();
                in_strm_sts_i[3*s + b] = 1'b1;
                read_word("R3 R4 R5 input stream walk", 32'h8000_0000 | (32'h1 << s));
                clear_src();
                out_strm_sts_i[3*s + b] = 1'b1;
                read_word("R3 R4 R5 output stream walk", 32'h8000_0000 | (32'h10 << s));
            end
        end

        // R2: each controller source alone
        clear_src(); rsp_evt_i  = 1; read_word("R2 response", 32'hC000_0000);
        clear_src(); rsp_ovf_i  = 1; read_word("R2 overrun", 32'hC000_0000);
        clear_src(); line_chg_i = 1; read_word("R2 line change", 32'hC000_0000);
        clear_src(); read_word("R1 R8 all clear", 32'h0);

        // R8: one-cycle pulse appears in status exactly one edge later
        in_strm_sts_i[5] = 1'b1;
        step();
        in_strm_sts_i = '0;
        rd_en_i = 1;
        step();
        rd_en_i = 0;
        check("R8 pulse captured", rd_data_o, 32'h8000_0002);

        // R7: enable gating
        out_strm_sts_i[11] = 1'b1;
        strm_en_i = 8'h80; glb_en_i = 0;
        step();
        check("R7 global off", {31'd0, irq_o}, 32'h0);
        glb_en_i = 1; #1;
        check("R7 stream enabled", {31'd0, irq_o}, 32'h1);
        strm_en_i = 8'h7F; #1;
        check("R7 other enables only", {31'd0, irq_o}, 32'h0);
        clear_src(); line_chg_i = 1; ctrl_en_i = 1;
        step();
        check("R7 controller enable", {31'd0, irq_o}, 32'h1);

        // R9: wake pulses leave status and irq unchanged
        pwr_wake_i = 1;
        read_word("R9 wake keeps status", 32'hC000_0000);
        check("R9 wake keeps irq", {31'd0, irq_o}, 32'h1);
        pwr_wake_i = 0;
        clear_src();

        // R10: reads have no effect; held data without strobe
        out_strm_sts_i[0] = 1'b1;
        read_word("R10 read value", 32'h8000_0010);
        clear_src();
        repeat (3) step();
        check("R10 hold without strobe", rd_data_o, 32'h8000_0010);

        // mixed patterns compared every clock by the model
        for (int i = 0; i < 400; i++) begin
            rsp_evt_i      = ($urandom % 8) == 0;
            rsp_ovf_i      = ($urandom % 8) == 0;
            line_chg_i     = ($urandom % 8) == 0;
            in_strm_sts_i  = 12'($urandom) & 12'($urandom) & 12'($urandom);
            out_strm_sts_i = 12'($urandom) & 12'($urandom) & 12'($urandom);
            strm_en_i      = 8'($urandom);
            ctrl_en_i      = $urandom % 2;
            glb_en_i       = ($urandom % 4) != 0;
            pwr_wake_i     = ($urandom % 6) == 0;
            rd_en_i        = $urandom % 2;
            step();
        end
        rd_en_i = 0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule